// File: doc/BRIEF.md
# Parallel NOR Flash Identity Probe

This block identifies a 32-bit parallel NOR flash bank made of two x16 devices side by side, so that each 16-bit half of the data bus reaches one device. After a start pulse it drives the three-write unlock and ID-mode command onto the flash bus. Every command byte is repeated in both halves of the word so that both devices see it. It then waits a settle time counted in clock cycles. Next it reads the identity words at word offsets 0, 1, 14 and 15 and decodes them into a descriptor: vendor family, device kind, sector count and total bank size in bytes. Last, it writes the vendor's return-to-read command.

Once the probe has finished, a combinational lookup port turns a sector index into that sector's byte offset from the start of the bank. It uses the non-uniform bottom-boot map or the uniform map, depending on the device found. The host starts the probe, waits for the done flag, and reads the descriptor and the lookup port.

Top module: `nor_id_probe`

## Requirements
- R1: An accepted start makes the block issue three single-cycle writes in consecutive cycles: 0x00AA00AA to word 0x555, then 0x00550055 to word 0x2AA, then 0x00900090 to word 0x555.
- R2: No read strobe occurs until at least CLK_HZ/1e6 × SETTLE_US cycles after the third command write. The reads then target word offsets 0, 1, 14 and 15. Read data is taken one cycle after the read strobe, and read and write strobes are never high together.
- R3: Only bits [7:0] of word 0 select the vendor. 0x01 gives vendor code 1, and 0x89 gives vendor code 2. Any other value gives vendor 0, device 0, a sector count of 0 and a size of 0.
- R4: With a known vendor, word 1 equal to 0x22492249 gives device code 1, 35 sectors and a size of 0x00400000.
- R5: With a known vendor, word 1 equal to 0x227E227E gives device code 2, 256 sectors and a size of 0x02000000, but only if word 14 equals 0x22122212 and word 15 equals 0x22002200. If either check fails, the result is device 0, a count of 0 and a size of 0.
- R6: Any other word 1 value gives device 0, a count of 0 and a size of 0.
- R7: As its final write, the probe writes 0x00F000F0 to word 0 for vendor 1 or 0x00FF00FF to word 0 for vendor 2. For vendor 0 it makes no final write.
- R8: The done flag rises when the probe completes and stays high until the next start. That start clears it in the following cycle. A start that arrives while a probe is running is ignored.
- R9: For device 1, sectors 0 to 3 start at offsets 0x0, 0x8000, 0xC000 and 0x10000. Sector i, for i ≥ 4, starts at i×0x20000 − 0x60000.
- R10: For device 2, sector i starts at i×0x20000.
- R11: A sector index at or above the sector count returns offset 0 with the invalid flag set. Valid indices keep the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a probe |
| done | output | 1 | Probe complete, held until the next start |
| vendor | output | 2 | 0 unknown, 1 family A (0x01), 2 family B (0x89) |
| dev_kind | output | 2 | 0 unknown, 1 bottom-boot, 2 uniform |
| sector_cnt | output | SECT_W | Number of sectors |
| bank_bytes | output | 32 | Total bank size in bytes |
| sec_idx | input | SECT_W | Sector index to look up |
| sec_off | output | 32 | Byte offset of that sector |
| sec_bad | output | 1 | Index is outside the sector count |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data, valid the cycle after fl_rd |
| fl_wr | output | 1 | Flash write strobe |
| fl_rd | output | 1 | Flash read strobe |

## Verification
Two functions can land in the same cycle: the final return-to-read write and a new start request from the host. The bench watches the flash bus for that final write and raises start in exactly that cycle. It then checks that no second command sequence appears, that done still rises and stays high, and that the descriptor matches the one decoded. A second overlap occurs when a start clears the descriptor while a lookup index is being held. The lookup result must fall back to invalid in the next cycle.

// File: rtl/nor_probe_pkg.sv
// Shared types and identity constants for the NOR identity probe.
// Assumes a 32-bit bank of two x16 devices; every constant repeats per half.
package nor_probe_pkg;

    typedef enum logic [1:0] {
        VEN_NONE  = 2'd0,
        VEN_FAM_A = 2'd1,
        VEN_FAM_B = 2'd2
    } vendor_t;

    typedef enum logic [1:0] {
        DEV_NONE   = 2'd0,
        DEV_BOTTOM = 2'd1,
        DEV_UNIF   = 2'd2
    } dev_t;

    localparam logic [7:0]  MFR_A      = 8'h01;
    localparam logic [7:0]  MFR_B      = 8'h89;
    localparam logic [31:0] ID_BOTTOM  = 32'h2249_2249;
    localparam logic [31:0] ID_MIRROR  = 32'h227E_227E;
    localparam logic [31:0] ID_EXT1    = 32'h2212_2212;
    localparam logic [31:0] ID_EXT2    = 32'h2200_2200;

    localparam logic [31:0] CMD_UNLK1  = 32'h00AA_00AA;
    localparam logic [31:0] CMD_UNLK2  = 32'h0055_0055;
    localparam logic [31:0] CMD_IDMODE = 32'h0090_0090;
    localparam logic [31:0] CMD_RD_A   = 32'h00F0_00F0;
    localparam logic [31:0] CMD_RD_B   = 32'h00FF_00FF;

    localparam int unsigned OFS_UNLK1  = 'h555;
    localparam int unsigned OFS_UNLK2  = 'h2AA;

endpackage

// File: rtl/nor_probe_seq.sv
// Probe sequencer: drives the command writes, the settle wait, the four
// identity reads and the final return-to-read write.
// Assumes read data is valid one cycle after fl_rd.
module nor_probe_seq
    import nor_probe_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned ADDR_W    = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  vendor_t           vendor_i,
    output logic              done,
    output logic              load,
    output logic              clear,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [31:0]       fl_wdata,
    output logic              fl_wr,
    output logic              fl_rd,
    input  logic [31:0]       fl_rdata,
    output logic [31:0]       w0,
    output logic [31:0]       w1,
    output logic [31:0]       w14,
    output logic [31:0]       w15
);
    localparam int unsigned CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
    localparam int unsigned SETTLE_CYC = (CYC_PER_US * SETTLE_US > 0) ? CYC_PER_US * SETTLE_US : 1;
    localparam int unsigned CW         = $clog2(SETTLE_CYC + 1);

    typedef enum logic [3:0] {
        S_IDLE, S_CMD1, S_CMD2, S_CMD3, S_WAIT,
        S_RD0, S_CP0, S_RD1, S_CP1, S_RD14, S_CP14, S_RD15, S_CP15,
        S_FIN, S_DONE
    } st_t;

    st_t           st;
    logic [CW-1:0] wcnt;

    assign clear = start && (st == S_IDLE || st == S_DONE);
    assign done  = (st == S_DONE);
    assign load  = (st == S_FIN);

    // State progression and settle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            wcnt <= '0;
        end else begin
            case (st)
                S_IDLE, S_DONE: if (start) st <= S_CMD1;
                S_CMD1: st <= S_CMD2;
                S_CMD2: st <= S_CMD3;
                S_CMD3: begin
                    st   <= S_WAIT;
                    wcnt <= '0;
                end
                S_WAIT: begin
                    if (wcnt == CW'(SETTLE_CYC - 1)) st <= S_RD0;
                    else wcnt <= wcnt + 1'b1;
                end
                S_RD0:  st <= S_CP0;
                S_CP0:  st <= S_RD1;
                S_RD1:  st <= S_CP1;
                S_CP1:  st <= S_RD14;
                S_RD14: st <= S_CP14;
                S_CP14: st <= S_RD15;
                S_RD15: st <= S_CP15;
                S_CP15: st <= S_FIN;
                S_FIN:  st <= S_DONE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Capture identity words one cycle after each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w0 <= '0; w1 <= '0; w14 <= '0; w15 <= '0;
        end else begin
            if (st == S_CP0)  w0  <= fl_rdata;
            if (st == S_CP1)  w1  <= fl_rdata;
            if (st == S_CP14) w14 <= fl_rdata;
            if (st == S_CP15) w15 <= fl_rdata;
        end
    end

    // Flash bus drive, decoded from the current state.
    always_comb begin
        fl_addr  = '0;
        fl_wdata = '0;
        fl_wr    = 1'b0;
        fl_rd    = 1'b0;
        case (st)
            S_CMD1: begin fl_wr = 1'b1; fl_addr = ADDR_W'(OFS_UNLK1); fl_wdata = CMD_UNLK1;  end
            S_CMD2: begin fl_wr = 1'b1; fl_addr = ADDR_W'(OFS_UNLK2); fl_wdata = CMD_UNLK2;  end
            S_CMD3: begin fl_wr = 1'b1; fl_addr = ADDR_W'(OFS_UNLK1); fl_wdata = CMD_IDMODE; end
            S_RD0:  begin fl_rd = 1'b1; fl_addr = ADDR_W'(0);  end
            S_RD1:  begin fl_rd = 1'b1; fl_addr = ADDR_W'(1);  end
            S_RD14: begin fl_rd = 1'b1; fl_addr = ADDR_W'(14); end
            S_RD15: begin fl_rd = 1'b1; fl_addr = ADDR_W'(15); end
            S_FIN: begin
                fl_wr    = (vendor_i != VEN_NONE);
                fl_wdata = (vendor_i == VEN_FAM_B) ? CMD_RD_B : CMD_RD_A;
            end
            default: ;
        endcase
    end

    // R1: the second unlock write is followed at once by the ID-mode write.
    assert_cmd_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && fl_wdata == CMD_UNLK2) |=>
        (fl_wr && fl_addr == ADDR_W'(OFS_UNLK1) && fl_wdata == CMD_IDMODE));

    // R2: read and write strobes never overlap.
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_wr && fl_rd));

    // R8: done holds until a start arrives.
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

// File: rtl/nor_probe_decode.sv
// Identity decoder: turns the four captured words into vendor, device kind,
// sector count and bank size. Purely combinational.
module nor_probe_decode
    import nor_probe_pkg::*;
#(
    parameter int unsigned SECT_W = 9
) (
    input  logic [31:0]       w0,
    input  logic [31:0]       w1,
    input  logic [31:0]       w14,
    input  logic [31:0]       w15,
    output vendor_t           vendor,
    output dev_t              kind,
    output logic [SECT_W-1:0] count,
    output logic [31:0]       bytes
);
    // Vendor from the low byte of word 0, then device from words 1, 14, 15.
    always_comb begin
        case (w0[7:0])
            MFR_A:   vendor = VEN_FAM_A;
            MFR_B:   vendor = VEN_FAM_B;
            default: vendor = VEN_NONE;
        endcase
        kind  = DEV_NONE;
        count = '0;
        bytes = '0;
        if (vendor != VEN_NONE) begin
            if (w1 == ID_BOTTOM) begin
                kind  = DEV_BOTTOM;
                count = SECT_W'(35);
                bytes = 32'h0040_0000;
            end else if (w1 == ID_MIRROR && w14 == ID_EXT1 && w15 == ID_EXT2) begin
                kind  = DEV_UNIF;
                count = SECT_W'(256);
                bytes = 32'h0200_0000;
            end
        end
    end

endmodule

// File: rtl/nor_probe_secmap.sv
// Sector map: byte offset of a sector index for the detected device kind.
// Assumes count is zero whenever kind is DEV_NONE.
module nor_probe_secmap
    import nor_probe_pkg::*;
#(
    parameter int unsigned SECT_W = 9
) (
    input  dev_t              kind,
    input  logic [SECT_W-1:0] count,
    input  logic [SECT_W-1:0] idx,
    output logic [31:0]       off,
    output logic              bad
);
    localparam int unsigned BLK_SH = 17;  // 128 KiB main sector

    logic [31:0] linear;
    logic [31:0] boot_head [4];

    assign linear = 32'(idx) << BLK_SH;

    // The four small sectors at the bottom of a bottom-boot device.
    genvar g;
    generate
        for (g = 0; g < 4; g++) begin : g_head
            localparam logic [31:0] HEAD = (g == 0) ? 32'h0 : (g == 1) ? 32'h8000 :
                                           (g == 2) ? 32'hC000 : 32'h1_0000;
            assign boot_head[g] = HEAD;
        end
    endgenerate

    // Offset selection and range check.
    always_comb begin
        bad = (idx >= count);
        off = '0;
        if (!bad) begin
            case (kind)
                DEV_BOTTOM: off = (idx < SECT_W'(4)) ? boot_head[idx[1:0]]
                                                     : linear - 32'h6_0000;
                DEV_UNIF:   off = linear;
                default:    off = '0;
            endcase
        end
    end

endmodule

// File: rtl/nor_id_probe.sv
// Top of the NOR identity probe: sequencer, decoder, descriptor registers
// and sector lookup. Descriptor is cleared by an accepted start and loaded
// in the last probe cycle.
module nor_id_probe
    import nor_probe_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned SECT_W    = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [1:0]        vendor,
    output logic [1:0]        dev_kind,
    output logic [SECT_W-1:0] sector_cnt,
    output logic [31:0]       bank_bytes,
    input  logic [SECT_W-1:0] sec_idx,
    output logic [31:0]       sec_off,
    output logic              sec_bad,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [31:0]       fl_wdata,
    input  logic [31:0]       fl_rdata,
    output logic              fl_wr,
    output logic              fl_rd
);
    logic              load, clear;
    logic [31:0]       w0, w1, w14, w15;
    vendor_t           dec_ven;
    dev_t              dec_kind;
    logic [SECT_W-1:0] dec_cnt;
    logic [31:0]       dec_bytes;
    vendor_t           ven_q;
    dev_t              kind_q;

    nor_probe_seq #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .vendor_i(dec_ven),
        .done(done), .load(load), .clear(clear),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd),
        .fl_rdata(fl_rdata), .w0(w0), .w1(w1), .w14(w14), .w15(w15)
    );

    nor_probe_decode #(.SECT_W(SECT_W)) u_dec (
        .w0(w0), .w1(w1), .w14(w14), .w15(w15),
        .vendor(dec_ven), .kind(dec_kind), .count(dec_cnt), .bytes(dec_bytes)
    );

    // Descriptor registers: cleared on accepted start, loaded at probe end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            ven_q      <= VEN_NONE;
            kind_q     <= DEV_NONE;
            sector_cnt <= '0;
            bank_bytes <= '0;
        end else if (load) begin
            ven_q      <= dec_ven;
            kind_q     <= dec_kind;
            sector_cnt <= dec_cnt;
            bank_bytes <= dec_bytes;
        end
    end

    assign vendor   = ven_q;
    assign dev_kind = kind_q;

    nor_probe_secmap #(.SECT_W(SECT_W)) u_map (
        .kind(kind_q), .count(sector_cnt), .idx(sec_idx),
        .off(sec_off), .bad(sec_bad)
    );

    // R3: an unknown vendor never reports sectors or size.
    assert_unknown_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vendor == 2'd0) |-> (sector_cnt == '0 && bank_bytes == '0));

    // R11: a valid lookup always lies inside the sector count.
    assert_lookup_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_bad |-> (sec_idx < sector_cnt));

    // R11: an invalid lookup yields offset zero.
    assert_bad_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sec_bad |-> (sec_off == 32'h0));

endmodule

// File: tb/nor_id_probe_test.sv
module nor_id_probe_test;
    localparam int unsigned CLK_HZ    = 125_000_000;
    localparam int unsigned SETTLE_US = 1;
    localparam int unsigned SETTLE_CYC = 125;
    localparam int unsigned ADDR_W    = 22;
    localparam int unsigned SECT_W    = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              done;
    logic [1:0]        vendor, dev_kind;
    logic [SECT_W-1:0] sector_cnt, sec_idx = '0;
    logic [31:0]       bank_bytes, sec_off, fl_wdata, fl_rdata;
    logic              sec_bad, fl_wr, fl_rd;
    logic [ADDR_W-1:0] fl_addr;

    always #4 clk = ~clk;

    nor_id_probe #(.CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .ADDR_W(ADDR_W), .SECT_W(SECT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .vendor(vendor),
        .dev_kind(dev_kind), .sector_cnt(sector_cnt), .bank_bytes(bank_bytes),
        .sec_idx(sec_idx), .sec_off(sec_off), .sec_bad(sec_bad),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_wr(fl_wr), .fl_rd(fl_rd)
    );

    // Flash model: identity words and a log of bus activity.
    logic [31:0] m_w0, m_w1, m_w14, m_w15;
    logic        log_clr = 1'b0;
    int          cyc = 0, nwr = 0, nrd = 0, cmd3_cyc = -1, rd_cyc = -1;
    logic [31:0] wa [16], wd [16];
    logic [31:0] ra [8];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        fl_rdata <= 32'hDEAD_BEEF;
        if (fl_rd) begin
            case (fl_addr)
                ADDR_W'(0):  fl_rdata <= m_w0;
                ADDR_W'(1):  fl_rdata <= m_w1;
                ADDR_W'(14): fl_rdata <= m_w14;
                ADDR_W'(15): fl_rdata <= m_w15;
                default:     fl_rdata <= 32'h0;
            endcase
        end
        if (log_clr) begin
            nwr <= 0; nrd <= 0; cmd3_cyc <= -1; rd_cyc <= -1;
        end else begin
            if (fl_wr && nwr < 16) begin
                wa[nwr] <= 32'(fl_addr); wd[nwr] <= fl_wdata; nwr <= nwr + 1;
                if (nwr == 2) cmd3_cyc <= cyc;
            end
            if (fl_rd && nrd < 8) begin
                ra[nrd] <= 32'(fl_addr); nrd <= nrd + 1;
                if (nrd == 0) rd_cyc <= cyc;
            end
        end
    end

    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        int k;
        k = 0;
        while (!done && k < 2000) begin @(negedge clk); k++; end
        chk(done === 1'b1, "R8 done timeout", 32'(done), 32'h1);
    endtask

    task automatic look(input string req, input int idx, input logic [31:0] exp_off, input bit exp_bad);
        @(negedge clk); sec_idx = SECT_W'(idx);
        #1;
        eq(req, sec_off, exp_off);
        eq(req, 32'(sec_bad), 32'(exp_bad));
    endtask

    typedef struct packed {
        logic [31:0] w0, w1, w14, w15;
        logic [1:0]  ven, kind;
        logic [8:0]  cnt;
        logic [31:0] size, rdcmd;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{32'h0001_0001, 32'h2249_2249, 32'h0, 32'h0, 2'd1, 2'd1, 9'd35,  32'h0040_0000, 32'h00F0_00F0},
        '{32'h0001_0001, 32'h227E_227E, 32'h2212_2212, 32'h2200_2200, 2'd1, 2'd2, 9'd256, 32'h0200_0000, 32'h00F0_00F0},
        '{32'h0001_0001, 32'h227E_227E, 32'h2213_2213, 32'h2200_2200, 2'd1, 2'd0, 9'd0, 32'h0, 32'h00F0_00F0},
        '{32'h0001_0001, 32'h227E_227E, 32'h2212_2212, 32'h2201_2201, 2'd1, 2'd0, 9'd0, 32'h0, 32'h00F0_00F0},
        '{32'h0001_0001, 32'h1234_1234, 32'h2212_2212, 32'h2200_2200, 2'd1, 2'd0, 9'd0, 32'h0, 32'h00F0_00F0},
        '{32'h0089_0089, 32'h2249_2249, 32'h0, 32'h0, 2'd2, 2'd1, 9'd35,  32'h0040_0000, 32'h00FF_00FF},
        '{32'hFFFF_AB01, 32'h2249_2249, 32'h0, 32'h0, 2'd1, 2'd1, 9'd35,  32'h0040_0000, 32'h00F0_00F0},
        '{32'h0000_0002, 32'h2249_2249, 32'h0, 32'h0, 2'd0, 2'd0, 9'd0, 32'h0, 32'h0},
        '{32'h0100_0100, 32'h227E_227E, 32'h2212_2212, 32'h2200_2200, 2'd0, 2'd0, 9'd0, 32'h0, 32'h0}
    };

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        m_w0 = 0; m_w1 = 0; m_w14 = 0; m_w15 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        eq("R8 reset done", 32'(done), 32'h0);
        eq("R3 reset vendor", 32'(vendor), 32'h0);
        eq("R11 reset lookup bad", 32'(sec_bad), 32'h1);
        eq("R2 reset strobes", 32'({fl_wr, fl_rd}), 32'h0);

        for (int v = 0; v < NV; v++) begin
            m_w0 = VEC[v].w0; m_w1 = VEC[v].w1; m_w14 = VEC[v].w14; m_w15 = VEC[v].w15;
            pulse_start();
            wait_done();
            @(negedge clk);
            eq("R3 vendor", 32'(vendor), 32'(VEC[v].ven));
            eq("R4 R5 R6 device kind", 32'(dev_kind), 32'(VEC[v].kind));
            eq("R4 R5 R6 sector count", 32'(sector_cnt), 32'(VEC[v].cnt));
            eq("R4 R5 R6 bank size", bank_bytes, VEC[v].size);
            chk(nwr >= 3 && wa[0] == 32'h555 && wd[0] == 32'h00AA_00AA &&
                wa[1] == 32'h2AA && wd[1] == 32'h0055_0055 &&
                wa[2] == 32'h555 && wd[2] == 32'h0090_0090, "R1 command sequence",
                wd[2], 32'h0090_0090);
            chk(rd_cyc - cmd3_cyc >= int'(SETTLE_CYC), "R2 settle gap",
                32'(rd_cyc - cmd3_cyc), 32'(SETTLE_CYC));
            chk(nrd == 4 && ra[0] == 0 && ra[1] == 1 && ra[2] == 14 && ra[3] == 15,
                "R2 read offsets", 32'(nrd), 32'd4);
            if (VEC[v].rdcmd == 32'h0) begin
                eq("R7 no final write", 32'(nwr), 32'd3);
            end else begin
                eq("R7 final write count", 32'(nwr), 32'd4);
                eq("R7 final write data", wd[3], VEC[v].rdcmd);
                eq("R7 final write addr", wa[3], 32'h0);
            end
            if (VEC[v].kind == 2'd1) begin
                look("R9 idx0", 0, 32'h0, 1'b0);
                look("R9 idx1", 1, 32'h8000, 1'b0);
                look("R9 idx2", 2, 32'hC000, 1'b0);
                look("R9 idx3", 3, 32'h1_0000, 1'b0);
                look("R9 idx4", 4, 32'h2_0000, 1'b0);
                look("R9 idx5", 5, 32'h4_0000, 1'b0);
                look("R9 idx34", 34, 32'h3E_0000, 1'b0);
                look("R11 idx35", 35, 32'h0, 1'b1);
            end else if (VEC[v].kind == 2'd2) begin
                look("R10 idx0", 0, 32'h0, 1'b0);
                look("R10 idx1", 1, 32'h2_0000, 1'b0);
                look("R10 idx255", 255, 32'h1FE_0000, 1'b0);
                look("R11 idx256", 256, 32'h0, 1'b1);
                look("R11 idx511", 511, 32'h0, 1'b1);
            end else begin
                look("R11 unknown idx0", 0, 32'h0, 1'b1);
            end
        end

        // Start during a running probe is ignored; done holds afterwards.
        m_w0 = VEC[0].w0; m_w1 = VEC[0].w1;
        pulse_start();
        repeat (20) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done();
        eq("R8 busy start ignored", 32'(nwr), 32'd4);
        repeat (5) @(negedge clk);
        eq("R8 done holds", 32'(done), 32'h1);

        // Start in the same cycle as the final return-to-read write.
        sec_idx = SECT_W'(4);
        pulse_start();
        while (!(fl_wr && fl_wdata == 32'h00F0_00F0)) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        eq("R8 done after overlap start", 32'(done), 32'h1);
        repeat (4) @(negedge clk);
        eq("R8 overlap no restart", 32'(nwr), 32'd4);
        eq("R8 overlap done holds", 32'(done), 32'h1);
        eq("R9 overlap lookup", sec_off, 32'h2_0000);

        // Start from done clears done and the descriptor in the next cycle.
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        eq("R8 start clears done", 32'(done), 32'h0);
        eq("R11 cleared lookup bad", 32'(sec_bad), 32'h1);
        eq("R11 cleared lookup off", sec_off, 32'h0);
        wait_done();

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule